// File: doc/BRIEF.md
# Hash Sigma Mixing Unit

This block is a single-cycle 32-bit execution unit for a processor pipeline. It evaluates one of six fixed bit-mixing functions that a hash compression function uses. Four of the functions combine two logical shifts and two left rotations of the operand by XOR. The other two XOR the operand with a right-shifted copy of itself. The shift and rotate amounts of each function are built into the hardware, so the datapath contains only wiring, XOR gates, a selector and one adder.

The unit supports two instruction forms. In the plain form it returns the selected mixing function of operand X, and operand Y is ignored. In the fused form it adds operand Y to that value modulo 2^32 in the same cycle. This saves the separate add instruction that almost always follows. An operation is issued by raising the valid strobe for one clock with the operands, function index and form bit. The result register loads at that clock edge. The done output is high for the one cycle that follows, and the result stays unchanged until the next issued operation.

Top module: `sigma_mix_unit`

## Requirements
- R1: While reset is applied and right after it is released, result is 0, done is 0 and illegal is 0.
- R2: With fnSel = 0..3 and modeFused = 0, an issued operation produces (X >> a) ^ (X << b) ^ rotl(X, c) ^ rotl(X, d), where (a,b,c,d) is (1,3,4,19) for index 0, (1,2,8,23) for index 1, (2,1,12,25) for index 2 and (2,2,15,29) for index 3.
- R3: With fnSel = 4 or 5 and modeFused = 0, an issued operation produces (X >> 1) ^ X for index 4 and (X >> 2) ^ X for index 5.
- R4: With modeFused = 1 and fnSel = 0..5, the result is the function value of R2/R3 plus Y, truncated to 32 bits, so a carry out of bit 31 is dropped.
- R5: With modeFused = 0, operand Y has no effect on the result.
- R6: With fnSel = 6 or 7, in either form, the result is 0 and illegal is 1. An issued operation with fnSel = 0..5 sets illegal to 0.
- R7: When inValid is 0 at a clock edge, result and illegal keep their values whatever X, Y, fnSel and modeFused are.
- R8: done is 1 exactly in the cycle after a clock edge at which inValid was 1, and 0 otherwise.
- R9: Operations issued on consecutive cycles each produce their own result, one per cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Issue strobe; operands are taken at this edge |
| modeFused | input | 1 | 0: plain function, 1: function plus Y |
| fnSel | input | 3 | Mixing function index 0..5; 6 and 7 are illegal |
| opX | input | 32 | Operand that is mixed |
| opY | input | 32 | Addend for the fused form |
| result | output | 32 | Registered result |
| done | output | 1 | High in the cycle after an issue |
| illegal | output | 1 | Registered flag for an out-of-range index |

## Verification
Each function index is driven with single-bit operands at the low and high ends, all-ones, and irregular patterns. A lone low bit shows whether each left shift or rotate amount is right. A lone bit 31 separates a rotate, which wraps the bit to the low end, from a shift, which drops it. All-ones separates the XOR of an even number of terms from that of an odd number. Fused operations use addends that force a carry out of bit 31, which shows that the sum wraps rather than saturates. Plain operations are repeated with different Y values to show that Y is ignored. Idle cycles with changing inputs show that the result holds. Back-to-back issues show that there is no stall between operations.

// File: rtl/sigma_mix_pkg.sv
package sigma_mix_pkg;

  localparam int NUM_FUNCS = 6;
  localparam int NUM_FULL  = 4;
  localparam int SEL_W     = $clog2(NUM_FUNCS + 1);

  typedef struct packed {
    logic                 loadEn;
    logic                 addEn;
    logic                 legal;
    logic [NUM_FUNCS-1:0] selHot;
  } ctrlStrobes_t;

  // term 0: right shift, 1: left shift, 2 and 3: left rotates
  function automatic int fullAmt(input int idx, input int term);
    int amt;
    case (idx * 4 + term)
      0:  amt = 1;   1:  amt = 3;   2:  amt = 4;   3:  amt = 19;
      4:  amt = 1;   5:  amt = 2;   6:  amt = 8;   7:  amt = 23;
      8:  amt = 2;   9:  amt = 1;   10: amt = 12;  11: amt = 25;
      12: amt = 2;   13: amt = 2;   14: amt = 15;  15: amt = 29;
      default: amt = 0;
    endcase
    return amt;
  endfunction

  // right shift of the two-term functions
  function automatic int lightAmt(input int idx);
    return idx - NUM_FULL + 1;
  endfunction

endpackage

// File: rtl/sigma_mix_ctrl.sv
module sigma_mix_ctrl
  import sigma_mix_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             modeFused,
  input  logic [SEL_W-1:0] fnSel,
  output ctrlStrobes_t     strb,
  output logic             doneQ,
  output logic             illegalQ
);

  logic legalSel;
  assign legalSel = (fnSel < SEL_W'(NUM_FUNCS));

  generate
    for (genvar k = 0; k < NUM_FUNCS; k++) begin : gDec
      assign strb.selHot[k] = (fnSel == SEL_W'(k));
    end
  endgenerate

  assign strb.legal  = legalSel;
  assign strb.addEn  = modeFused & legalSel;
  assign strb.loadEn = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ    <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      doneQ <= inValid;
      if (inValid) illegalQ <= ~legalSel;
    end
  end

endmodule

// File: rtl/sigma_mix_dp.sv
module sigma_mix_dp
  import sigma_mix_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [WIDTH-1:0] opX,
  input  logic [WIDTH-1:0] opY,
  output logic [WIDTH-1:0] resultQ
);

  logic [WIDTH-1:0] candVal [NUM_FUNCS];
  logic [WIDTH-1:0] sigmaVal;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sumVal;

  generate
    for (genvar g = 0; g < NUM_FUNCS; g++) begin : gFunc
      if (g < NUM_FULL) begin : gFull
        localparam int SR = fullAmt(g, 0);
        localparam int SL = fullAmt(g, 1);
        localparam int RA = fullAmt(g, 2);
        localparam int RB = fullAmt(g, 3);
        logic [WIDTH-1:0] rotA, rotB;
        assign rotA = (opX << RA) | (opX >> (WIDTH - RA));
        assign rotB = (opX << RB) | (opX >> (WIDTH - RB));
        assign candVal[g] = (opX >> SR) ^ (opX << SL) ^ rotA ^ rotB;
      end else begin : gLight
        localparam int SR = lightAmt(g);
        assign candVal[g] = (opX >> SR) ^ opX;
      end
    end
  endgenerate

  always_comb begin
    sigmaVal = '0;
    for (int k = 0; k < NUM_FUNCS; k++) begin
      if (strb.selHot[k]) sigmaVal = sigmaVal | candVal[k];
    end
  end

  assign addend = strb.addEn ? opY : '0;
  assign sumVal = sigmaVal + addend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            resultQ <= '0;
    else if (strb.loadEn) resultQ <= sumVal;
  end

endmodule

// File: rtl/sigma_mix_unit.sv
module sigma_mix_unit
  import sigma_mix_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        modeFused,
  input  logic [2:0]  fnSel,
  input  logic [31:0] opX,
  input  logic [31:0] opY,
  output logic [31:0] result,
  output logic        done,
  output logic        illegal
);

  ctrlStrobes_t strb;

  sigma_mix_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .modeFused(modeFused),
    .fnSel    (fnSel),
    .strb     (strb),
    .doneQ    (done),
    .illegalQ (illegal)
  );

  sigma_mix_dp #(.WIDTH(32)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opX    (opX),
    .opY    (opY),
    .resultQ(result)
  );

endmodule

// File: rtl/sigma_mix_chk.sv
module sigma_mix_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        modeFused,
  input logic [2:0]  fnSel,
  input logic [31:0] opX,
  input logic [31:0] opY,
  input logic [31:0] result,
  input logic        done,
  input logic        illegal
);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |-> (result == 32'd0 && !done && !illegal)); // R1

  AST_S4_PLAIN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !modeFused && fnSel == 3'd4) |=> result == (($past(opX) >> 1) ^ $past(opX))); // R3

  AST_S5_FUSED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeFused && fnSel == 3'd5) |=>
      result == ((($past(opX) >> 2) ^ $past(opX)) + $past(opY))); // R4

  AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fnSel >= 3'd6) |=> (illegal && result == 32'd0)); // R6

  AST_GOOD_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fnSel < 3'd6) |=> !illegal); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(illegal))); // R7

  AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> done); // R8

  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !done); // R8

endmodule

bind sigma_mix_unit sigma_mix_chk uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .modeFused(modeFused),
  .fnSel(fnSel), .opX(opX), .opY(opY), .result(result), .done(done),
  .illegal(illegal)
);

// File: tb/sigma_mix_unit_test.sv
`timescale 1ns/1ps
module sigma_mix_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        modeFused = 1'b0;
  logic [2:0]  fnSel = 3'd0;
  logic [31:0] opX = 32'd0;
  logic [31:0] opY = 32'd0;
  logic [31:0] result;
  logic        done;
  logic        illegal;

  int checkCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  sigma_mix_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeFused(modeFused),
    .fnSel(fnSel), .opX(opX), .opY(opY), .result(result), .done(done),
    .illegal(illegal)
  );

  localparam int NVEC = 14;
  localparam logic [1:0]  VMODE [NVEC] = '{0,0,0,0,0,0,0,0,1,1,1,1,1,1};
  localparam logic [2:0]  VFN   [NVEC] = '{0,1,2,3,0,3,4,5,0,1,2,3,4,5};
  localparam logic [31:0] VX    [NVEC] = '{
    32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
    32'h8000_0000, 32'h0000_0001, 32'hA5A5_A5A5, 32'hFFFF_FFFF,
    32'hDEAD_BEEF, 32'h0F0F_0F0F, 32'h0000_0001, 32'h8000_0001,
    32'hFFFF_FFFF, 32'h1357_9BDF};
  localparam logic [31:0] VY    [NVEC] = '{
    32'hFFFF_FFFF, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333,
    32'h4444_4444, 32'h5555_5555, 32'h6666_6666, 32'h7777_7777,
    32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'hF000_0000,
    32'h8000_0000, 32'hFFFF_FFFE};

  function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [31:0] refVal(input logic fused, input logic [2:0] f,
                                         input logic [31:0] x, input logic [31:0] y);
    logic [31:0] s;
    case (f)
      3'd0: s = (x >> 1) ^ (x << 3) ^ rotl(x, 4)  ^ rotl(x, 19);
      3'd1: s = (x >> 1) ^ (x << 2) ^ rotl(x, 8)  ^ rotl(x, 23);
      3'd2: s = (x >> 2) ^ (x << 1) ^ rotl(x, 12) ^ rotl(x, 25);
      3'd3: s = (x >> 2) ^ (x << 2) ^ rotl(x, 15) ^ rotl(x, 29);
      3'd4: s = (x >> 1) ^ x;
      3'd5: s = (x >> 2) ^ x;
      default: return 32'd0;
    endcase
    return fused ? s + y : s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic m, input logic [2:0] f, input logic [31:0] x,
                       input logic [31:0] y);
    @(negedge clk);
    inValid = 1'b1; modeFused = m; fnSel = f; opX = x; opY = y;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 result", result, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 illegal", {31'd0, illegal}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", result, 32'd0);

    // R2 R3 R4: vector table
    for (int i = 0; i < NVEC; i++) begin
      issue(VMODE[i][0], VFN[i], VX[i], VY[i]);
      check(VMODE[i][0] ? "R4 fused" : (VFN[i] < 3'd4 ? "R2 four-term" : "R3 two-term"),
            result, refVal(VMODE[i][0], VFN[i], VX[i], VY[i]));
      check("R8 done after issue", {31'd0, done}, 32'd1);
      check("R6 legal no flag", {31'd0, illegal}, 32'd0);
    end

    // R4 carry out dropped: s4(FFFFFFFF)=80000000, +80000000 wraps to 0
    issue(1'b1, 3'd4, 32'hFFFF_FFFF, 32'h8000_0000);
    check("R4 wrap", result, 32'd0);

    // R5 Y ignored in plain form
    issue(1'b0, 3'd2, 32'hCAFE_F00D, 32'h0000_0000);
    held = result;
    issue(1'b0, 3'd2, 32'hCAFE_F00D, 32'hFFFF_FFFF);
    check("R5 y ignored", result, held);
    check("R5 y ignored value", result, refVal(1'b0, 3'd2, 32'hCAFE_F00D, 32'd0));

    // R6 illegal indices
    issue(1'b0, 3'd6, 32'h1234_5678, 32'h0);
    check("R6 idx6 result", result, 32'd0);
    check("R6 idx6 flag", {31'd0, illegal}, 32'd1);
    issue(1'b1, 3'd7, 32'h1234_5678, 32'h9999_9999);
    check("R6 idx7 fused result", result, 32'd0);
    check("R6 idx7 flag", {31'd0, illegal}, 32'd1);

    // R7 hold while idle, illegal flag kept
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      modeFused = c[0]; fnSel = 3'(c); opX = 32'hFFFF_0000 ^ 32'(c); opY = 32'h1;
      check("R7 idle result hold", result, 32'd0);
      check("R7 idle illegal hold", {31'd0, illegal}, 32'd1);
      check("R8 no done idle", {31'd0, done}, 32'd0);
    end
    issue(1'b0, 3'd1, 32'h0000_0100, 32'h0);
    check("R6 flag cleared", {31'd0, illegal}, 32'd0);
    held = result;
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      opX = 32'h5555_0000 + 32'(c); fnSel = 3'd3;
      check("R7 idle hold legal", result, held);
    end

    // R9 back-to-back issues
    @(negedge clk);
    inValid = 1'b1; modeFused = 1'b0; fnSel = 3'd0; opX = 32'h0000_0010; opY = 32'h0;
    @(negedge clk);
    check("R9 first", result, refVal(1'b0, 3'd0, 32'h0000_0010, 32'h0));
    check("R9 done first", {31'd0, done}, 32'd1);
    modeFused = 1'b1; fnSel = 3'd5; opX = 32'h8888_8888; opY = 32'h0000_0003;
    @(negedge clk);
    check("R9 second", result, refVal(1'b1, 3'd5, 32'h8888_8888, 32'h3));
    check("R9 done second", {31'd0, done}, 32'd1);
    inValid = 1'b0;
    @(negedge clk);
    check("R8 done drops", {31'd0, done}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule